// File: doc/BRIEF.md
# Cascadable Three-Counter Watchdog Core

This block is the counting core of a watchdog timer. It advances on a slow tick enable that is sampled on the fast clock. It holds two 16-bit counters and one 32-bit counter. Each can run on its own tick, or the three can be chained so that the next counter advances when its predecessor hits its match value or wraps. Each 16-bit counter has a match value and a match action, which can do nothing, raise an interrupt, reset the device, or raise interrupts and reset on the third unserviced hit. Each also has a window floor: servicing the counter while its value is still below that floor can trigger its own action. The 32-bit counter raises an interrupt one tick after a chosen bit of it flips, and it never resets the device.

Register access, write protection and interrupt masking sit in the surrounding logic. That logic presents the configuration as static inputs, turns software service writes into one-cycle strobes, and collects the one-cycle interrupt and reset pulses that this core emits.

Top module: `wdog_trio_core`

## Requirements
- R1: An enabled counter in independent mode (link code 0, or the unused code 3) steps by one on every cycle with `tick` high. A disabled counter holds its value and produces no hit, wrap or carry.
- R2: A 16-bit counter k hits when `tick` steps it while its value equals `lo_match[k]`. The effect depends on `hit_act[k]`: code 0 does nothing, code 1 pulses `irq[k]`, and code 2 pulses `dev_rst`.
- R3: With `hit_act[k]` = 3, every hit pulses `irq[k]`. The third hit in a row without a service or clear also pulses `dev_rst`, and the count of hits then starts again.
- R4: With `lo_autoclr[k]` set, a hit returns the counter to zero on the same edge, so the next hit comes `lo_match[k]`+1 ticks later.
- R5: With a link code of 1, the successor counter steps only on the ticks where its predecessor hits. `link_lo` chains counter 0 to counter 1, and `link_hi` chains counter 1 to counter 2.
- R6: With a link code of 2, the successor counter steps only on the tick where its predecessor wraps from all ones to zero.
- R7: When a link is not independent and its pair bit is set, the successor counts as hit only if its predecessor's value also equals its match value in the same cycle.
- R8: With `hi_irq_en` high, a step of counter 2 that flips bit `hi_bit` makes `irq[2]` pulse on the next tick. Counter 2 never drives `dev_rst`. With `hi_irq_en` low, `irq[2]` stays low.
- R9: A service strobe `svc[k]` that arrives while counter k is below `lo_floor[k]` triggers `early_act[k]`: code 0 does nothing, code 1 pulses `irq[k]`, and code 2 pulses `dev_rst`.
- R10: `svc[k]` returns counter k to zero and clears its count of unserviced hits. The counter produces no hit in that cycle.
- R11: `ctr_clr[k]` returns counter k to zero. It has priority over service and tick, and it clears the unserviced-hit count and any pending 32-bit interrupt.
- R12: `irq` and `dev_rst` are registered one-clock pulses that appear on the clock after the causing edge. `dev_rst` stays low unless a reset action code is in use.
- R13: While `rst` is high and right after it, all counters are zero and `irq` and `dev_rst` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Slow count enable, one cycle per count |
| svc | input | 2 | Service strobes for the 16-bit counters |
| ctr_en | input | 3 | Per-counter enables |
| ctr_clr | input | 3 | Per-counter clear requests |
| lo_match | input | 2x16 | Match values of the 16-bit counters |
| lo_floor | input | 2x16 | Window floors of the 16-bit counters |
| hit_act | input | 2x2 | Match action codes |
| early_act | input | 2x2 | Early-service action codes |
| lo_autoclr | input | 2 | Clear-on-hit enables |
| link_lo | input | 2 | Link mode, counter 0 to 1 |
| link_hi | input | 2 | Link mode, counter 1 to 2 |
| pair_lo | input | 1 | Double-match condition for link 0 to 1 |
| pair_hi | input | 1 | Double-match condition for link 1 to 2 |
| hi_irq_en | input | 1 | Enables the bit-flip interrupt of counter 2 |
| hi_bit | input | 5 | Bit index watched on counter 2 |
| irq | output | 3 | Interrupt pulses, bit k for counter k |
| dev_rst | output | 1 | Device reset pulse |

## Verification
The assertions take the configuration inputs as quasi-static. The window and escalation checks rely on the action codes staying unchanged through the cycles that the properties look back over. The stimulus changes configuration only between test phases, always on the falling clock edge, and clears every counter after each change. Tick, service and clear strobes are each driven for exactly one cycle from the falling edge, so every property sees a stable value at each rising edge.

// File: rtl/wdog_trio_pkg.sv
package wdog_trio_pkg;

    typedef enum logic [1:0] {
        LINK_SOLO    = 2'd0,
        LINK_ON_HIT  = 2'd1,
        LINK_ON_WRAP = 2'd2,
        LINK_SPARE   = 2'd3
    } link_e;

    typedef enum logic [1:0] {
        HIT_NONE  = 2'd0,
        HIT_IRQ   = 2'd1,
        HIT_RESET = 2'd2,
        HIT_ESC   = 2'd3
    } hit_act_e;

    typedef enum logic [1:0] {
        EARLY_NONE  = 2'd0,
        EARLY_IRQ   = 2'd1,
        EARLY_RESET = 2'd2,
        EARLY_SPARE = 2'd3
    } early_act_e;

    typedef struct packed {
        logic hit;
        logic wrap;
    } ctr_ev_t;

    typedef struct packed {
        logic irq;
        logic rst;
    } req_t;

    // number of hits in a row that escalate to a device reset
    localparam int unsigned ESC_HITS = 3;

    function automatic logic link_carry(link_e mode, ctr_ev_t pred);
        case (mode)
            LINK_ON_HIT:  return pred.hit;
            LINK_ON_WRAP: return pred.wrap;
            default:      return 1'b1;
        endcase
    endfunction

    function automatic logic pair_gate(link_e mode, logic pair, logic pred_raw);
        if ((mode == LINK_ON_HIT || mode == LINK_ON_WRAP) && pair)
            return pred_raw;
        return 1'b1;
    endfunction

endpackage

// File: rtl/wdog_lo_ctr.sv
module wdog_lo_ctr
    import wdog_trio_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic         svc,
    input  logic         clr,
    input  logic         pair_ok,
    input  logic [W-1:0] mval,
    input  logic [W-1:0] floor_val,
    input  logic [1:0]   act,
    input  logic [1:0]   eact,
    input  logic         autoclr,
    output logic [W-1:0] cnt,
    output logic         raw,
    output ctr_ev_t      ev,
    output req_t         req
);
    localparam int unsigned MISS_W = $clog2(ESC_HITS);
    localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(ESC_HITS - 1);

    logic [W-1:0]      cnt_q;
    logic [MISS_W-1:0] miss_q;
    logic              step, hit, early, last;
    hit_act_e          hact;
    early_act_e        ract;

    assign hact  = hit_act_e'(act);
    assign ract  = early_act_e'(eact);
    assign step  = adv & ~svc & ~clr;
    assign raw   = step & (cnt_q == mval);
    assign hit   = raw & pair_ok;
    assign early = svc & ~clr & (cnt_q < floor_val);
    assign last  = (miss_q == MISS_LAST);

    assign ev.hit  = hit;
    assign ev.wrap = step & (&cnt_q);
    assign cnt     = cnt_q;

    assign req.irq = (hit & (hact == HIT_IRQ || hact == HIT_ESC))
                   | (early & (ract == EARLY_IRQ));
    assign req.rst = (hit & (hact == HIT_RESET || (hact == HIT_ESC && last)))
                   | (early & (ract == EARLY_RESET));

    always_ff @(posedge clk) begin
        if (rst || clr || svc) begin
            cnt_q  <= '0;
            miss_q <= '0;
        end else begin
            if (step)
                cnt_q <= (hit && autoclr) ? '0 : cnt_q + 1'b1;
            if (hit && hact == HIT_ESC)
                miss_q <= last ? '0 : miss_q + 1'b1;
        end
    end

endmodule

// File: rtl/wdog_hi_ctr.sv
module wdog_hi_ctr #(
    parameter int unsigned W = 32,
    localparam int unsigned SW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          adv,
    input  logic          clr,
    input  logic          pair_ok,
    input  logic          bit_en,
    input  logic [SW-1:0] bit_sel,
    output logic [W-1:0]  cnt,
    output logic          irq_req
);
    logic [W-1:0] cnt_q, below;
    logic         step, flip, pend_q;

    // the watched bit flips on a step when every bit under it is one
    assign below   = (W'(1) << bit_sel) - W'(1);
    assign step    = adv & ~clr;
    assign flip    = step & (&(cnt_q | ~below)) & bit_en & pair_ok;
    assign irq_req = tick & pend_q & bit_en;
    assign cnt     = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (step)
                cnt_q <= cnt_q + 1'b1;
            pend_q <= bit_en & (flip | (pend_q & ~tick));
        end
    end

endmodule

// File: rtl/wdog_trio_core.sv
module wdog_trio_core
    import wdog_trio_pkg::*;
#(
    parameter int unsigned LO_W = 16,
    parameter int unsigned HI_W = 32,
    localparam int unsigned SEL_W = $clog2(HI_W),
    localparam int unsigned N_LO = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      tick,
    input  logic [N_LO-1:0]           svc,
    input  logic [N_LO:0]             ctr_en,
    input  logic [N_LO:0]             ctr_clr,
    input  logic [N_LO-1:0][LO_W-1:0] lo_match,
    input  logic [N_LO-1:0][LO_W-1:0] lo_floor,
    input  logic [N_LO-1:0][1:0]      hit_act,
    input  logic [N_LO-1:0][1:0]      early_act,
    input  logic [N_LO-1:0]           lo_autoclr,
    input  logic [1:0]                link_lo,
    input  logic [1:0]                link_hi,
    input  logic                      pair_lo,
    input  logic                      pair_hi,
    input  logic                      hi_irq_en,
    input  logic [SEL_W-1:0]          hi_bit,
    output logic [N_LO:0]             irq,
    output logic                      dev_rst
);
    logic [N_LO-1:0][LO_W-1:0] lo_cnt;
    logic [HI_W-1:0]           hi_cnt;
    logic                      lo_raw  [N_LO];
    ctr_ev_t                   lo_ev   [N_LO];
    req_t                      lo_req  [N_LO];
    logic                      lo_adv  [N_LO];
    logic                      lo_pair [N_LO];
    logic [N_LO:0]             irq_d;
    logic [N_LO-1:0]           rst_d;
    logic                      hi_adv, hi_pair, hi_irq;

    for (genvar g = 0; g < N_LO; g++) begin : g_lo
        if (g == 0) begin : g_head
            assign lo_adv[g]  = tick & ctr_en[g];
            assign lo_pair[g] = 1'b1;
        end else begin : g_link
            assign lo_adv[g]  = tick & ctr_en[g] & link_carry(link_e'(link_lo), lo_ev[g-1]);
            assign lo_pair[g] = pair_gate(link_e'(link_lo), pair_lo, lo_raw[g-1]);
        end

        wdog_lo_ctr #(.W(LO_W)) u_ctr (
            .clk       (clk),
            .rst       (rst),
            .adv       (lo_adv[g]),
            .svc       (svc[g]),
            .clr       (ctr_clr[g]),
            .pair_ok   (lo_pair[g]),
            .mval      (lo_match[g]),
            .floor_val (lo_floor[g]),
            .act       (hit_act[g]),
            .eact      (early_act[g]),
            .autoclr   (lo_autoclr[g]),
            .cnt       (lo_cnt[g]),
            .raw       (lo_raw[g]),
            .ev        (lo_ev[g]),
            .req       (lo_req[g])
        );

        assign irq_d[g] = lo_req[g].irq;
        assign rst_d[g] = lo_req[g].rst;
    end

    assign hi_adv  = tick & ctr_en[N_LO] & link_carry(link_e'(link_hi), lo_ev[N_LO-1]);
    assign hi_pair = pair_gate(link_e'(link_hi), pair_hi, lo_raw[N_LO-1]);

    wdog_hi_ctr #(.W(HI_W)) u_hi (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .adv     (hi_adv),
        .clr     (ctr_clr[N_LO]),
        .pair_ok (hi_pair),
        .bit_en  (hi_irq_en),
        .bit_sel (hi_bit),
        .cnt     (hi_cnt),
        .irq_req (hi_irq)
    );

    assign irq_d[N_LO] = hi_irq;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq     <= '0;
            dev_rst <= 1'b0;
        end else begin
            irq     <= irq_d;
            dev_rst <= |rst_d;
        end
    end

endmodule

// File: rtl/wdog_trio_chk.sv
module wdog_trio_chk #(
    parameter int unsigned LO_W = 16,
    parameter int unsigned HI_W = 32
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 tick,
    input logic [1:0]           svc,
    input logic [2:0]           ctr_en,
    input logic [2:0]           ctr_clr,
    input logic [1:0][1:0]      hit_act,
    input logic [1:0][1:0]      early_act,
    input logic                 hi_irq_en,
    input logic [2:0]           irq,
    input logic                 dev_rst,
    input logic [1:0][LO_W-1:0] lo_cnt,
    input logic [HI_W-1:0]      hi_cnt
);
    // R2, R9: interrupt 0 only follows a tick or a service strobe
    a_r2_irq0_cause: assert property (@(posedge clk) disable iff (rst)
        irq[0] |-> $past(tick || svc[0]));

    // R12: a reset pulse needs a reset-capable action code one cycle earlier
    a_r12_rst_needs_code: assert property (@(posedge clk) disable iff (rst)
        dev_rst |-> $past(hit_act[0][1] || hit_act[1][1] ||
                          early_act[0] == 2'd2 || early_act[1] == 2'd2));

    // R8: the wide counter interrupt follows an enabled tick
    a_r8_irq2_cause: assert property (@(posedge clk) disable iff (rst)
        irq[2] |-> $past(tick && hi_irq_en));

    // R1: a disabled, unserviced, uncleared counter holds
    a_r1_hold: assert property (@(posedge clk) disable iff (rst)
        (!ctr_en[0] && !svc[0] && !ctr_clr[0]) |=> $stable(lo_cnt[0]));

    // R10: service returns counter 1 to zero
    a_r10_svc_zero: assert property (@(posedge clk) disable iff (rst)
        (svc[1] && !ctr_clr[1]) |=> (lo_cnt[1] == '0));

    // R11: clear returns the wide counter to zero
    a_r11_hi_zero: assert property (@(posedge clk) disable iff (rst)
        ctr_clr[2] |=> (hi_cnt == '0));

endmodule

bind wdog_trio_core wdog_trio_chk #(.LO_W(LO_W), .HI_W(HI_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .svc       (svc),
    .ctr_en    (ctr_en),
    .ctr_clr   (ctr_clr),
    .hit_act   (hit_act),
    .early_act (early_act),
    .hi_irq_en (hi_irq_en),
    .irq       (irq),
    .dev_rst   (dev_rst),
    .lo_cnt    (lo_cnt),
    .hi_cnt    (hi_cnt)
);

// File: tb/sim_wdog_trio_core.sv
`timescale 1ns/1ps
module sim_wdog_trio_core;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            tick = 1'b0;
    logic [1:0]      svc = '0;
    logic [2:0]      ctr_en = '0;
    logic [2:0]      ctr_clr = '0;
    logic [1:0][15:0] lo_match = '0;
    logic [1:0][15:0] lo_floor = '0;
    logic [1:0][1:0] hit_act = '0;
    logic [1:0][1:0] early_act = '0;
    logic [1:0]      lo_autoclr = '0;
    logic [1:0]      link_lo = '0;
    logic [1:0]      link_hi = '0;
    logic            pair_lo = 1'b0;
    logic            pair_hi = 1'b0;
    logic            hi_irq_en = 1'b0;
    logic [4:0]      hi_bit = '0;
    logic [2:0]      irq;
    logic            dev_rst;

    always #2.5 clk = ~clk;

    wdog_trio_core u0 (
        .clk(clk), .rst(rst), .tick(tick), .svc(svc), .ctr_en(ctr_en),
        .ctr_clr(ctr_clr), .lo_match(lo_match), .lo_floor(lo_floor),
        .hit_act(hit_act), .early_act(early_act), .lo_autoclr(lo_autoclr),
        .link_lo(link_lo), .link_hi(link_hi), .pair_lo(pair_lo),
        .pair_hi(pair_hi), .hi_irq_en(hi_irq_en), .hi_bit(hi_bit),
        .irq(irq), .dev_rst(dev_rst)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_tag = "R13";
    int    n_irq [3];
    int    n_rst = 0;
    bit    done = 1'b0;

    // behavioural reference model
    int     mc [2];
    int     mm [2];
    longint m2 = 0;
    bit     mpend = 1'b0;
    logic [2:0] exp_irq = '0;
    logic       exp_rst = 1'b0;

    always @(posedge clk) begin
        bit adv [2];
        bit raw [2];
        bit hit [2];
        bit wrp [2];
        bit early, gate, carry, rr, adv2, tog, ir2;
        bit [2:0] ir;
        longint span;
        if (rst) begin
            mc[0] = 0; mc[1] = 0; mm[0] = 0; mm[1] = 0;
            m2 = 0; mpend = 0; exp_irq = '0; exp_rst = 1'b0;
        end else begin
            rr = 0; ir = '0;
            for (int k = 0; k < 2; k++) begin
                carry = 1;
                if (k == 1 && link_lo == 2'd1) carry = hit[0];
                if (k == 1 && link_lo == 2'd2) carry = wrp[0];
                adv[k] = tick && ctr_en[k] && carry && !svc[k] && !ctr_clr[k];
                raw[k] = adv[k] && (mc[k] == int'(lo_match[k]));
                wrp[k] = adv[k] && (mc[k] == 65535);
                gate = 1;
                if (k == 1 && (link_lo == 2'd1 || link_lo == 2'd2) && pair_lo) gate = raw[0];
                hit[k] = raw[k] && gate;
                early = svc[k] && !ctr_clr[k] && (mc[k] < int'(lo_floor[k]));
                ir[k] = (hit[k] && (hit_act[k] == 2'd1 || hit_act[k] == 2'd3)) ||
                        (early && early_act[k] == 2'd1);
                if ((hit[k] && (hit_act[k] == 2'd2 || (hit_act[k] == 2'd3 && mm[k] == 2))) ||
                    (early && early_act[k] == 2'd2)) rr = 1;
                if (ctr_clr[k] || svc[k]) begin
                    mm[k] = 0; mc[k] = 0;
                end else begin
                    if (hit[k] && hit_act[k] == 2'd3) mm[k] = (mm[k] == 2) ? 0 : mm[k] + 1;
                    if (adv[k]) mc[k] = (hit[k] && lo_autoclr[k]) ? 0 : (mc[k] + 1) % 65536;
                end
            end
            carry = 1;
            if (link_hi == 2'd1) carry = hit[1];
            if (link_hi == 2'd2) carry = wrp[1];
            adv2 = tick && ctr_en[2] && carry && !ctr_clr[2];
            span = longint'(1) << hi_bit;
            gate = 1;
            if ((link_hi == 2'd1 || link_hi == 2'd2) && pair_hi) gate = raw[1];
            tog = adv2 && ((m2 % span) == span - 1) && hi_irq_en && gate;
            ir2 = tick && mpend && hi_irq_en;
            if (ctr_clr[2]) begin
                m2 = 0; mpend = 0;
            end else begin
                mpend = hi_irq_en && (tog || (mpend && !tick));
                if (adv2) m2 = (m2 + 1) % (longint'(1) << 32);
            end
            ir[2] = ir2;
            exp_irq = ir;
            exp_rst = rr;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            n_chk++;
            if (irq !== exp_irq || dev_rst !== exp_rst) begin
                n_bad++;
                $display("FAIL %s cycle compare: irq=%b rst=%b expected irq=%b rst=%b",
                         cur_tag, irq, dev_rst, exp_irq, exp_rst);
            end
            for (int k = 0; k < 3; k++) if (irq[k] === 1'b1) n_irq[k]++;
            if (dev_rst === 1'b1) n_rst++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic zero_counts();
        n_irq[0] = 0; n_irq[1] = 0; n_irq[2] = 0; n_rst = 0;
    endtask

    task automatic run_ticks(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            for (int j = 1; j < gap; j++) begin
                @(negedge clk); tick = 1'b0;
            end
        end
        @(negedge clk); tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_all();
        @(negedge clk); ctr_clr = 3'b111;
        @(negedge clk); ctr_clr = 3'b000;
        @(negedge clk);
        zero_counts();
    endtask

    task automatic service(input int k);
        @(negedge clk); svc[k] = 1'b1;
        @(negedge clk); svc = '0;
        @(negedge clk);
    endtask

    task automatic defaults();
        @(negedge clk);
        ctr_en = '0; lo_match = '0; lo_floor = '0; hit_act = '0; early_act = '0;
        lo_autoclr = '0; link_lo = '0; link_hi = '0; pair_lo = 0; pair_hi = 0;
        hi_irq_en = 0; hi_bit = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R12 watchdog expired: actual still running expected finished");
        $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        zero_counts();
        repeat (4) @(negedge clk);
        chk("R13 irq in reset", int'(irq), 0);
        chk("R13 rst in reset", int'(dev_rst), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R13 irq after reset", int'(irq), 0);

        // R2: interrupt action, hit on fourth tick
        cur_tag = "R2"; defaults(); clear_all();
        ctr_en = 3'b001; lo_match[0] = 16'd3; hit_act[0] = 2'd1;
        run_ticks(10, 2);
        chk("R2 irq0 pulses", n_irq[0], 1);
        chk("R2 no reset on irq code", n_rst, 0);
        clear_all(); hit_act[0] = 2'd2;
        run_ticks(10, 2);
        chk("R2 reset pulses", n_rst, 1);
        chk("R2 no irq on reset code", n_irq[0], 0);
        cur_tag = "R12"; clear_all(); hit_act[0] = 2'd0;
        run_ticks(10, 1);
        chk("R12 no reset with code 0", n_rst, 0);
        chk("R12 no irq with code 0", n_irq[0], 0);

        // R4: clear on hit
        cur_tag = "R4"; defaults(); clear_all();
        ctr_en = 3'b001; lo_match[0] = 16'd2; hit_act[0] = 2'd1; lo_autoclr[0] = 1;
        run_ticks(30, 1);
        chk("R4 periodic hits", n_irq[0], 10);

        // R3: escalation
        cur_tag = "R3"; defaults(); clear_all();
        ctr_en = 3'b001; lo_match[0] = 16'd1; hit_act[0] = 2'd3; lo_autoclr[0] = 1;
        run_ticks(12, 1);
        chk("R3 irq per hit", n_irq[0], 6);
        chk("R3 reset every third hit", n_rst, 2);

        // R10: service clears the hit count
        cur_tag = "R10"; clear_all();
        for (int r = 0; r < 4; r++) begin
            run_ticks(4, 1);
            service(0);
        end
        chk("R10 no escalation when serviced", n_rst, 0);
        chk("R10 irq still per hit", n_irq[0], 8);

        // R9: window floor
        cur_tag = "R9"; defaults(); clear_all();
        ctr_en = 3'b001; lo_floor[0] = 16'd5; early_act[0] = 2'd1;
        run_ticks(2, 1); service(0);
        chk("R9 early irq", n_irq[0], 1);
        early_act[0] = 2'd2;
        run_ticks(2, 1); service(0);
        chk("R9 early reset", n_rst, 1);
        run_ticks(6, 1); service(0);
        chk("R9 late service quiet irq", n_irq[0], 1);
        chk("R9 late service quiet rst", n_rst, 1);

        // R11 and R1: clear and hold
        cur_tag = "R11"; defaults(); clear_all();
        ctr_en = 3'b001; lo_match[0] = 16'd4; hit_act[0] = 2'd1;
        run_ticks(3, 1);
        @(negedge clk); ctr_clr = 3'b001; @(negedge clk); ctr_clr = '0;
        cur_tag = "R1"; ctr_en = 3'b000;
        run_ticks(5, 1);
        ctr_en = 3'b001;
        run_ticks(4, 1);
        chk("R11 R1 no hit after clear and hold", n_irq[0], 0);
        run_ticks(1, 1);
        chk("R1 hit on fifth enabled tick", n_irq[0], 1);

        // R5: carry on hit, 0 to 1
        cur_tag = "R5"; defaults(); clear_all();
        ctr_en = 3'b011; link_lo = 2'd1; lo_match[0] = 16'd1; lo_autoclr[0] = 1;
        lo_match[1] = 16'd2; hit_act[1] = 2'd1;
        run_ticks(6, 1);
        chk("R5 successor hit", n_irq[1], 1);
        chk("R5 predecessor quiet", n_irq[0], 0);
        run_ticks(5, 1);
        chk("R5 no further hit", n_irq[1], 1);

        // R8: wide counter bit flip
        cur_tag = "R8"; defaults(); clear_all();
        ctr_en = 3'b100; hi_irq_en = 1; hi_bit = 5'd2;
        run_ticks(20, 3);
        chk("R8 bit 2 flips", n_irq[2], 4);
        chk("R8 never resets", n_rst, 0);
        hi_bit = 5'd0; clear_all();
        run_ticks(10, 1);
        chk("R8 bit 0 flips", n_irq[2], 9);
        hi_irq_en = 0; clear_all();
        run_ticks(10, 1);
        chk("R8 disabled quiet", n_irq[2], 0);

        // R5 and R7 on link 1 to 2
        cur_tag = "R7"; defaults(); clear_all();
        ctr_en = 3'b110; link_hi = 2'd1; pair_hi = 1; lo_match[1] = 16'd1;
        lo_autoclr[1] = 1; hi_irq_en = 1; hi_bit = 5'd0;
        run_ticks(10, 1);
        chk("R7 R5 chained wide counter", n_irq[2], 4);

        // R6 and R7: carry on wrap with double match
        cur_tag = "R6"; defaults(); clear_all();
        ctr_en = 3'b011; link_lo = 2'd2; pair_lo = 1; lo_match[0] = 16'hFFFF;
        lo_match[1] = 16'd0; hit_act[1] = 2'd1;
        run_ticks(65535, 1);
        chk("R6 no carry before wrap", n_irq[1], 0);
        run_ticks(1, 1);
        chk("R6 R7 carry on wrap", n_irq[1], 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule